// File: doc/BRIEF.md
# Scanline Window Mask Generator

This block decides, for every pixel of a scanline, which layers are masked by the two horizontal windows. Each window is a pixel span set by a left and a right edge. Six targets use the windows: four background layers, the sprite layer and the colour path. For each target, either window can be switched on and inverted on its own. When both windows are on, a two-bit rule merges them.

Software writes the settings through a byte-wide write port. The renderer drives the current horizontal coordinate and reads one mask bit per target in the same cycle. The settings are registered. The masks are combinational from those registers and the coordinate.

Address map (byte writes): 0 = window 1 left, 1 = window 1 right, 2 = window 2 left, 3 = window 2 right, 4 = select byte for BG1/BG2, 5 = select byte for BG3/BG4, 6 = select byte for sprites/colour, 7 = background rule byte, 8 = sprite/colour rule byte. Mask output bit order: bit0 BG1, bit1 BG2, bit2 BG3, bit3 BG4, bit4 sprites, bit5 colour.

Top module: `wmask_gen`

## Requirements
- R1: While reset is applied, all settings clear to zero. In the cycle after a reset edge every mask bit is 0 for any coordinate.
- R2: A window covers pixel x when left <= x <= right. Both edges are inclusive, and left == right covers exactly one pixel.
- R3: A window whose left edge is greater than its right edge covers no pixel.
- R4: A set invert bit flips that window's coverage before it is used for the target.
- R5: When exactly one window is enabled for a target, the mask equals that window's coverage (after invert), and the rule field has no effect.
- R6: When neither window is enabled for a target, its mask is 0, whatever its invert bits are.
- R7: When both windows are enabled, the rule code combines the two inverted coverages: 00 gives OR, 01 gives AND, 10 gives XOR, 11 gives XNOR.
- R8: The background rule byte (address 7) holds BG1 in bits 1:0, BG2 in bits 3:2, BG3 in bits 5:4 and BG4 in bits 7:6. The sprite/colour rule byte (address 8) holds sprites in bits 1:0 and colour in bits 3:2. Bits 7:4 of address 8 are ignored.
- R9: Each select byte (addresses 4 to 6) holds the first target of its pair in bits 3:0 and the second in bits 7:4. Within each nibble, bit0 is the window 1 invert, bit1 the window 1 enable, bit2 the window 2 invert and bit3 the window 2 enable.
- R10: A write to an address above 8, or any cycle with write enable low, changes no setting.
- R11: The masks follow the coordinate input in the same cycle. A setting write takes effect from the clock edge that captures it, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Setting write strobe |
| wr_addr | input | 4 | Setting byte address |
| wr_data | input | 8 | Setting byte value |
| pix_x | input | 8 | Current horizontal pixel coordinate |
| mask | output | 6 | Window mask per target (bit0 BG1 … bit5 colour) |

## Verification
The hardest situations to reach are those where one rule code must give different answers for different targets at the same pixel, while other targets in the same register have only one window enabled. Only then does a swapped nibble or a shifted rule field show up. The bench gives each target its own select nibble and rule code, offset by the target index. It steps the nibble base through all sixteen values and the rule base through all four. Every pixel coordinate is swept under overlapping, full-width, single-pixel and inverted-order (empty) windows. The same-cycle timing of a write is caught by sampling the mask just before and just after the capturing edge.

// File: rtl/wmask_pkg.sv
package wmask_pkg;
    localparam int PIX_W_DEF  = 8;
    localparam int N_BG_DEF   = 4;
    localparam int CFG_DATA_W = 8;
    localparam int CFG_ADDR_W = 4;

    // window w: left edge at 2w, right edge at 2w+1
    localparam int ADR_SEL_BASE  = 4;
    localparam int SEL_PER_BYTE  = 2;
    localparam int RULE_PER_BYTE = 4;

    // bit positions inside a select nibble
    localparam int NIB_INV1 = 0;
    localparam int NIB_EN1  = 1;
    localparam int NIB_INV2 = 2;
    localparam int NIB_EN2  = 3;

    typedef enum logic [1:0] {
        RULE_OR   = 2'b00,
        RULE_AND  = 2'b01,
        RULE_XOR  = 2'b10,
        RULE_XNOR = 2'b11
    } win_rule_e;
endpackage

// File: rtl/wmask_regs.sv
module wmask_regs
    import wmask_pkg::*;
#(
    parameter int PIX_W  = PIX_W_DEF,
    parameter int N_TGT  = N_BG_DEF + 2,
    parameter int ADDR_W = CFG_ADDR_W
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          wr_en,
    input  logic [ADDR_W-1:0]             wr_addr,
    input  logic [CFG_DATA_W-1:0]         wr_data,
    output logic [1:0][PIX_W-1:0]         win_lo,
    output logic [1:0][PIX_W-1:0]         win_hi,
    output logic [N_TGT-1:0]              en1,
    output logic [N_TGT-1:0]              inv1,
    output logic [N_TGT-1:0]              en2,
    output logic [N_TGT-1:0]              inv2,
    output logic [N_TGT-1:0][1:0]         rule
);
    localparam int SEL_BYTES = (N_TGT + SEL_PER_BYTE - 1) / SEL_PER_BYTE;
    localparam int RULE_BASE = ADR_SEL_BASE + SEL_BYTES;

    always_ff @(posedge clk) begin
        if (rst) begin
            win_lo <= '0;
            win_hi <= '0;
            en1    <= '0;
            inv1   <= '0;
            en2    <= '0;
            inv2   <= '0;
            rule   <= '0;
        end else if (wr_en) begin
            for (int w = 0; w < 2; w++) begin
                if (wr_addr == ADDR_W'(2 * w))
                    win_lo[w] <= wr_data[PIX_W-1:0];
                if (wr_addr == ADDR_W'(2 * w + 1))
                    win_hi[w] <= wr_data[PIX_W-1:0];
            end
            for (int t = 0; t < N_TGT; t++) begin
                if (wr_addr == ADDR_W'(ADR_SEL_BASE + t / SEL_PER_BYTE)) begin
                    inv1[t] <= wr_data[4 * (t % SEL_PER_BYTE) + NIB_INV1];
                    en1[t]  <= wr_data[4 * (t % SEL_PER_BYTE) + NIB_EN1];
                    inv2[t] <= wr_data[4 * (t % SEL_PER_BYTE) + NIB_INV2];
                    en2[t]  <= wr_data[4 * (t % SEL_PER_BYTE) + NIB_EN2];
                end
                if (wr_addr == ADDR_W'(RULE_BASE + t / RULE_PER_BYTE))
                    rule[t] <= wr_data[2 * (t % RULE_PER_BYTE) +: 2];
            end
        end
    end
endmodule

// File: rtl/wmask_range.sv
module wmask_range
    import wmask_pkg::*;
#(
    parameter int PIX_W = PIX_W_DEF
) (
    input  logic [PIX_W-1:0] pix_x,
    input  logic [PIX_W-1:0] edge_lo,
    input  logic [PIX_W-1:0] edge_hi,
    output logic             hit
);
    always_comb begin
        hit = (pix_x >= edge_lo) && (pix_x <= edge_hi);
    end
endmodule

// File: rtl/wmask_combine.sv
module wmask_combine
    import wmask_pkg::*;
(
    input  logic       hit1,
    input  logic       hit2,
    input  logic       en1,
    input  logic       inv1,
    input  logic       en2,
    input  logic       inv2,
    input  logic [1:0] rule,
    output logic       m
);
    logic a, b;

    always_comb begin
        a = hit1 ^ inv1;
        b = hit2 ^ inv2;
        unique case ({en1, en2})
            2'b00: m = 1'b0;
            2'b10: m = a;
            2'b01: m = b;
            2'b11: begin
                unique case (win_rule_e'(rule))
                    RULE_OR:   m = a | b;
                    RULE_AND:  m = a & b;
                    RULE_XOR:  m = a ^ b;
                    RULE_XNOR: m = ~(a ^ b);
                endcase
            end
        endcase
    end
endmodule

// File: rtl/wmask_gen.sv
module wmask_gen
    import wmask_pkg::*;
#(
    parameter int PIX_W  = PIX_W_DEF,
    parameter int N_BG   = N_BG_DEF,
    parameter int ADDR_W = CFG_ADDR_W
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          wr_en,
    input  logic [ADDR_W-1:0]             wr_addr,
    input  logic [CFG_DATA_W-1:0]         wr_data,
    input  logic [PIX_W-1:0]              pix_x,
    output logic [N_BG+1:0]               mask
);
    localparam int N_TGT = N_BG + 2;

    logic [1:0][PIX_W-1:0] win_lo;
    logic [1:0][PIX_W-1:0] win_hi;
    logic [N_TGT-1:0]      en1, inv1, en2, inv2;
    logic [N_TGT-1:0][1:0] rule;
    logic [1:0]            win_hit;

    wmask_regs #(
        .PIX_W  (PIX_W),
        .N_TGT  (N_TGT),
        .ADDR_W (ADDR_W)
    ) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .win_lo  (win_lo),
        .win_hi  (win_hi),
        .en1     (en1),
        .inv1    (inv1),
        .en2     (en2),
        .inv2    (inv2),
        .rule    (rule)
    );

    for (genvar w = 0; w < 2; w++) begin : g_win
        wmask_range #(.PIX_W(PIX_W)) u_rng (
            .pix_x   (pix_x),
            .edge_lo (win_lo[w]),
            .edge_hi (win_hi[w]),
            .hit     (win_hit[w])
        );
    end

    for (genvar t = 0; t < N_TGT; t++) begin : g_tgt
        wmask_combine u_cmb (
            .hit1 (win_hit[0]),
            .hit2 (win_hit[1]),
            .en1  (en1[t]),
            .inv1 (inv1[t]),
            .en2  (en2[t]),
            .inv2 (inv2[t]),
            .rule (rule[t]),
            .m    (mask[t])
        );
    end
endmodule

// File: rtl/wmask_chk.sv
module wmask_chk
    import wmask_pkg::*;
#(
    parameter int PIX_W  = PIX_W_DEF,
    parameter int N_TGT  = N_BG_DEF + 2,
    parameter int ADDR_W = CFG_ADDR_W
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  wr_en,
    input logic [ADDR_W-1:0]     wr_addr,
    input logic [N_TGT-1:0]      mask,
    input logic [1:0]            win_hit,
    input logic [1:0][PIX_W-1:0] win_lo,
    input logic [1:0][PIX_W-1:0] win_hi,
    input logic [N_TGT-1:0]      en1,
    input logic [N_TGT-1:0]      inv1,
    input logic [N_TGT-1:0]      en2,
    input logic [N_TGT-1:0]      inv2,
    input logic [N_TGT-1:0][1:0] rule
);
    localparam int SEL_BYTES  = (N_TGT + SEL_PER_BYTE - 1) / SEL_PER_BYTE;
    localparam int RULE_BYTES = (N_TGT + RULE_PER_BYTE - 1) / RULE_PER_BYTE;
    localparam int ADR_LAST   = ADR_SEL_BASE + SEL_BYTES + RULE_BYTES - 1;

    logic rst_q;
    always_ff @(posedge clk) begin
        rst_q <= rst;
        if (rst_q) begin
            AST_RESET_MASK_ZERO: assert (mask == '0); // R1
        end
    end

    for (genvar w = 0; w < 2; w++) begin : g_w
        AST_EMPTY_WINDOW: assert property (@(posedge clk) disable iff (rst)
            (win_lo[w] > win_hi[w]) |-> !win_hit[w]); // R3
    end

    for (genvar t = 0; t < N_TGT; t++) begin : g_t
        AST_NO_ENABLE_ZERO: assert property (@(posedge clk) disable iff (rst)
            (!en1[t] && !en2[t]) |-> !mask[t]); // R6
        AST_ONLY_W1: assert property (@(posedge clk) disable iff (rst)
            (en1[t] && !en2[t]) |-> (mask[t] == (win_hit[0] ^ inv1[t]))); // R5
        AST_ONLY_W2: assert property (@(posedge clk) disable iff (rst)
            (!en1[t] && en2[t]) |-> (mask[t] == (win_hit[1] ^ inv2[t]))); // R5
        AST_RULE_AND: assert property (@(posedge clk) disable iff (rst)
            (en1[t] && en2[t] && rule[t] == 2'b01)
            |-> (mask[t] == ((win_hit[0] ^ inv1[t]) & (win_hit[1] ^ inv2[t])))); // R7
        AST_RULE_XNOR: assert property (@(posedge clk) disable iff (rst)
            (en1[t] && en2[t] && rule[t] == 2'b11)
            |-> (mask[t] == ((win_hit[0] ^ inv1[t]) == (win_hit[1] ^ inv2[t])))); // R7
    end

    AST_UNMAPPED_WRITE: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr > ADDR_W'(ADR_LAST))
        |=> $stable({win_lo, win_hi, en1, inv1, en2, inv2, rule})); // R10
endmodule

bind wmask_gen wmask_chk #(
    .PIX_W  (PIX_W),
    .N_TGT  (N_TGT),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .mask    (mask),
    .win_hit (win_hit),
    .win_lo  (win_lo),
    .win_hi  (win_hi),
    .en1     (en1),
    .inv1    (inv1),
    .en2     (en2),
    .inv2    (inv2),
    .rule    (rule)
);

// File: tb/wmask_gen_tb.sv
module wmask_gen_tb;
    localparam int CLK_P = 10;
    localparam int NT    = 6;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [3:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [7:0] pix_x = '0;
    logic [5:0] mask;

    int n_chk  = 0;
    int n_fail = 0;

    // bench model of the settings
    int m_lo [2];
    int m_hi [2];
    bit m_en1 [NT], m_inv1 [NT], m_en2 [NT], m_inv2 [NT];
    int m_rule [NT];

    always #(CLK_P / 2) clk = ~clk;

    wmask_gen u_dut (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .pix_x   (pix_x),
        .mask    (mask)
    );

    task automatic model_clear();
        for (int w = 0; w < 2; w++) begin m_lo[w] = 0; m_hi[w] = 0; end
        for (int t = 0; t < NT; t++) begin
            m_en1[t] = 0; m_inv1[t] = 0; m_en2[t] = 0; m_inv2[t] = 0; m_rule[t] = 0;
        end
    endtask

    task automatic model_write(input int a, input int d);
        if (a < 4) begin
            if (a % 2 == 0) m_lo[a / 2] = d; else m_hi[a / 2] = d;
        end else if (a < 7) begin
            for (int k = 0; k < 2; k++) begin
                int t = 2 * (a - 4) + k;
                int nib = (d >> (4 * k)) & 15;
                m_inv1[t] = nib[0]; m_en1[t] = nib[1];
                m_inv2[t] = nib[2]; m_en2[t] = nib[3];
            end
        end else if (a == 7) begin
            for (int t = 0; t < 4; t++) m_rule[t] = (d >> (2 * t)) & 3;
        end else if (a == 8) begin
            m_rule[4] = d & 3;
            m_rule[5] = (d >> 2) & 3;
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 4'(a); wr_data = 8'(d);
        @(posedge clk);
        #1;
        wr_en = 1'b0;
        model_write(a, d);
    endtask

    function automatic bit exp_bit(int t, int xx);
        bit h1, h2, a, b;
        h1 = (xx >= m_lo[0]) && (xx <= m_hi[0]);
        h2 = (xx >= m_lo[1]) && (xx <= m_hi[1]);
        a = h1 ^ m_inv1[t];
        b = h2 ^ m_inv2[t];
        if (!m_en1[t] && !m_en2[t]) return 1'b0;
        if (m_en1[t] && !m_en2[t]) return a;
        if (!m_en1[t] && m_en2[t]) return b;
        case (m_rule[t])
            0: return a | b;
            1: return a & b;
            2: return a ^ b;
            default: return ~(a ^ b);
        endcase
    endfunction

    function automatic logic [5:0] exp_mask(int xx);
        logic [5:0] e;
        for (int t = 0; t < NT; t++) e[t] = exp_bit(t, xx);
        return e;
    endfunction

    function automatic string tag_of(int t);
        if (m_lo[0] > m_hi[0] || m_lo[1] > m_hi[1]) return "R3";
        if (!m_en1[t] && !m_en2[t]) return "R6";
        if (m_en1[t] != m_en2[t]) return (m_inv1[t] || m_inv2[t]) ? "R4" : "R5";
        return "R7";
    endfunction

    task automatic check_x(input int xx, input string tag);
        logic [5:0] e;
        pix_x = 8'(xx);
        #1;
        e = exp_mask(xx);
        n_chk++;
        if (mask !== e) begin
            n_fail++;
            for (int t = 0; t < NT; t++)
                if (mask[t] !== e[t])
                    $display("FAIL %s %s target %0d x=%0d actual=%0b expected=%0b",
                             tag, tag_of(t), t, xx, mask[t], e[t]);
        end
    endtask

    task automatic sweep(input string tag);
        for (int xx = 0; xx < 256; xx++) check_x(xx, tag);
    endtask

    // per-target nibble and rule, offset by target index (R8 R9)
    task automatic load_targets(input int nb, input int rb);
        int nib [NT];
        int rl [NT];
        for (int t = 0; t < NT; t++) begin
            nib[t] = (nb + 3 * t) % 16;
            rl[t]  = (rb + t) % 4;
        end
        for (int k = 0; k < 3; k++) wr(4 + k, nib[2 * k] | (nib[2 * k + 1] << 4));
        wr(7, rl[0] | (rl[1] << 2) | (rl[2] << 4) | (rl[3] << 6));
        wr(8, rl[4] | (rl[5] << 2) | 8'hA0); // upper bits ignored, R8
    endtask

    task automatic set_windows(input int l1, input int r1, input int l2, input int r2);
        wr(0, l1); wr(1, r1); wr(2, l2); wr(3, r2);
    endtask

    initial begin
        model_clear();
        repeat (3) @(posedge clk);
        // R1: reset state, masks zero everywhere
        #1;
        for (int xx = 0; xx < 256; xx += 51) check_x(xx, "R1");
        @(negedge clk);
        rst = 1'b0;
        check_x(0, "R1");
        check_x(255, "R1");

        // R2 R4 R5 R6 R7 R8 R9: overlapping windows
        set_windows(40, 120, 100, 200);
        for (int rb = 0; rb < 4; rb++)
            for (int nb = 0; nb < 16; nb++) begin
                load_targets(nb, rb);
                sweep("R2 R9");
            end

        // R2: full span and single pixel
        set_windows(0, 255, 77, 77);
        for (int rb = 0; rb < 4; rb++)
            for (int nb = 0; nb < 16; nb++) begin
                load_targets(nb, rb);
                sweep("R2 R8");
            end

        // R3: inverted-order windows are empty
        set_windows(150, 50, 31, 30);
        for (int nb = 0; nb < 16; nb++) begin
            load_targets(nb, nb % 4);
            sweep("R3");
        end

        // R10: unmapped addresses and idle cycles leave settings alone
        set_windows(40, 120, 100, 200);
        load_targets(11, 2);
        for (int a = 9; a < 16; a++) begin
            @(negedge clk);
            wr_en = 1'b1; wr_addr = 4'(a); wr_data = 8'hFF;
            @(posedge clk);
            #1;
            wr_en = 1'b0;
        end
        @(negedge clk);
        wr_en = 1'b0; wr_addr = 4'd0; wr_data = 8'd0;
        @(posedge clk);
        #1;
        sweep("R10");

        // R11: combinational x, write visible only after capturing edge
        set_windows(10, 20, 200, 100);
        load_targets(2, 0); // target0 nibble 2 = window 1 only
        for (int k = 0; k < 3; k++) wr(4 + k, 8'h22);
        check_x(15, "R11");
        check_x(9, "R11");
        check_x(21, "R11");
        @(negedge clk);
        pix_x = 8'd15;
        wr_en = 1'b1; wr_addr = 4'd0; wr_data = 8'd16;
        #1;
        n_chk++;
        if (mask !== 6'h3F) begin
            n_fail++;
            $display("FAIL R11 before edge actual=%0h expected=3f", mask);
        end
        @(posedge clk);
        #1;
        wr_en = 1'b0;
        model_write(0, 16);
        n_chk++;
        if (mask !== 6'h00) begin
            n_fail++;
            $display("FAIL R11 after edge actual=%0h expected=0", mask);
        end
        check_x(16, "R11");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule